// File: doc/BRIEF.md
# Asynchronous Read-Handshake Slave

This block is the slave end of a 16-bit parallel read link to an external master. The master has its own clock and shares no clock with this block. The master asks for one word by pulling an active-low read request low. The block takes the next word from a valid/ready source in its own clock domain, such as the output of a FIFO. It drives that word onto the data bus and then pulls an active-low acknowledge low. The master captures the word and raises its request. The block then raises acknowledge, which completes a full four-phase handshake.

The request first passes through a two-flop synchronizer. After that, a four-state machine controls the handshake. The states are `ST_IDLE`, `ST_FETCH`, `ST_PRESENT` and `ST_RELEASE`, and the transitions are:
- `ST_IDLE` goes to `ST_FETCH` when the synchronized request is seen low.
- `ST_FETCH` goes to `ST_PRESENT` on the cycle the source is valid. In that cycle the word is popped and loaded into the bus register.
- `ST_PRESENT` goes to `ST_RELEASE` once acknowledge is low and the request is seen high again.
- `ST_RELEASE` goes to `ST_IDLE` once acknowledge is back high and the request is still seen high.

Acknowledge is registered from the state, so it falls one clock after the bus register is loaded.

Top module: `rdhs_slave`

## Requirements
- R1: During and directly after reset, `ack_n_o` is 1, `bus_o` is 0 and `src_ready_o` is 0.
- R2: The request goes through a two-stage synchronizer. After `rd_req_n_i` falls, `ack_n_o` stays high through the third rising clock edge and is low after the fifth edge, provided the source holds a valid word.
- R3: A low level on the synchronized request while idle starts a transfer, and that transfer pops exactly one word from the source.
- R4: The word is on `bus_o` at least one clock cycle before `ack_n_o` falls, and `bus_o` does not change on the edge where `ack_n_o` falls.
- R5: While `ack_n_o` is low, `bus_o` and `ack_n_o` stay unchanged until the request is seen high.
- R6: After the request returns high, `ack_n_o` returns to 1. It never rises unless the synchronized request was high on the cycle before.
- R7: If the source is empty when a request arrives, `ack_n_o` stays 1 and nothing is popped until a word becomes valid. That word is then presented normally.
- R8: If the request goes low again before `ack_n_o` has risen, no new transfer starts. Acknowledge stays 1 and nothing is popped until the request has first gone high and then low again.
- R9: The source is popped (`src_valid_i & src_ready_o`) only while `ack_n_o` is 1, and exactly once per completed handshake. Words appear on the bus in source order.
- R10: While the request stays high, the block never pulls `ack_n_o` low and never pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| rd_req_n_i | input | 1 | Master read request, active low, asynchronous |
| ack_n_o | output | 1 | Data-valid acknowledge to master, active low |
| bus_o | output | 16 | Data bus toward the master |
| src_valid_i | input | 1 | Source has a word |
| src_ready_o | output | 1 | Block accepts the source word this cycle |
| src_data_i | input | 16 | Source word |

## Verification
The assertions take for granted that the master obeys the four-phase order. The master lowers its request only while acknowledge is high. It raises the request only after it has seen acknowledge low. The exception is the R8 case, where the request is deliberately dropped again before acknowledge rises. The assertions also assume the source holds its word steady while valid. The bench master changes the request only on falling clock edges, after it has observed acknowledge on the port. It holds every level for at least two slave clocks, so the synchronizer always captures it. The bench source presents words in push order and changes them only at falling edges.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_PRESENT = 2'd2,
        ST_RELEASE = 2'd3
    } rdhs_state_e;
endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdhs_stage.sv
module rdhs_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= data_i;
    end

    assign data_o = word_q;
endmodule

// File: rtl/rdhs_fsm.sv
module rdhs_fsm
    import rdhs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_act_i,
    input  logic src_valid_i,
    output logic src_ready_o,
    output logic load_o,
    output logic ack_n_o
);
    rdhs_state_e state_q, state_d;
    logic        ack_n_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_act_i)              state_d = ST_FETCH;
            ST_FETCH:   if (src_valid_i)            state_d = ST_PRESENT;
            ST_PRESENT: if (!req_act_i && !ack_n_q) state_d = ST_RELEASE;
            ST_RELEASE: if (ack_n_q && !req_act_i)  state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            ack_n_q <= (state_q != ST_PRESENT);
        end
    end

    always_comb begin
        src_ready_o = (state_q == ST_FETCH);
        load_o      = src_ready_o && src_valid_i;
        ack_n_o     = ack_n_q;
    end

    AST_POP_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready_o && src_valid_i) |-> ack_n_q) else $error("pop with ack low"); // R9
    AST_ACK_RISE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n_q) |-> $past(!req_act_i)) else $error("ack rose without request high"); // R6
    AST_RELEASE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q != ST_FETCH)) else $error("fetch from release"); // R8
    AST_IDLE_NO_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_act_i) |=> (state_q == ST_IDLE)) else $error("left idle without request"); // R10
endmodule

// File: rtl/rdhs_slave.sv
module rdhs_slave #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req_n_i,
    output logic             ack_n_o,
    output logic [WIDTH-1:0] bus_o,
    input  logic             src_valid_i,
    output logic             src_ready_o,
    input  logic [WIDTH-1:0] src_data_i
);
    logic req_n_sync;
    logic req_act;
    logic load;

    rdhs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(rd_req_n_i),
        .sync_o (req_n_sync)
    );

    assign req_act = ~req_n_sync;

    rdhs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_act_i  (req_act),
        .src_valid_i(src_valid_i),
        .src_ready_o(src_ready_o),
        .load_o     (load),
        .ack_n_o    (ack_n_o)
    );

    rdhs_stage #(.WIDTH(WIDTH)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .data_i(src_data_i),
        .data_o(bus_o)
    );

    AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> $stable(bus_o)) else $error("bus moved as ack fell"); // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && $past(!ack_n_o)) |-> $stable(bus_o)) else $error("bus moved during ack"); // R5
endmodule

// File: tb/rdhs_slave_test.sv
module rdhs_slave_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req_n = 1'b1;
    logic         ack_n;
    logic [W-1:0] bus;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic [W-1:0] src_data = '0;

    int checks = 0;
    int failures = 0;
    int pops = 0;
    int cyc = 0;
    bit done = 0;
    logic [W-1:0] src_q[$];
    logic [W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    rdhs_slave #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .rd_req_n_i(rd_req_n), .ack_n_o(ack_n),
        .bus_o(bus), .src_valid_i(src_valid), .src_ready_o(src_ready),
        .src_data_i(src_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_word(input logic [W-1:0] w);
        src_q.push_back(w);
        exp_q.push_back(w);
    endtask

    // source model: pop at rising edge, present at falling edge
    always @(posedge clk) begin
        if (rst_n && src_valid && src_ready) begin
            void'(src_q.pop_front());
            pops++;
        end
    end
    always @(negedge clk) begin
        src_valid <= (src_q.size() != 0);
        src_data  <= (src_q.size() != 0) ? src_q[0] : '0;
    end

    // monitor: scoreboard compare when ack falls
    logic prev_ack = 1'b1;
    always @(negedge clk) begin
        if (rst_n && prev_ack && !ack_n) begin
            if (exp_q.size() == 0) check("R9 unexpected word", 32'(bus), 32'hDEAD);
            else check("R9 word order", 32'(bus), 32'(exp_q.pop_front()));
        end
        prev_ack <= ack_n;
    end

    task automatic wait_ack(input logic lvl, input string req);
        int n = 0;
        while (ack_n !== lvl && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(req, 32'(ack_n), 32'(lvl));
    endtask

    task automatic read_word();
        logic [W-1:0] seen;
        rd_req_n = 1'b0;
        wait_ack(1'b0, "R3 ack low");
        seen = bus;
        repeat (3) @(negedge clk);
        check("R5 bus held", 32'(bus), 32'(seen));
        check("R5 ack held", 32'(ack_n), 32'd0);
        rd_req_n = 1'b1;
        wait_ack(1'b1, "R6 ack back high");
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        check("R1 ack in reset", 32'(ack_n), 32'd1);
        check("R1 bus in reset", 32'(bus), 32'd0);
        check("R1 ready in reset", 32'(src_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", 32'(ack_n), 32'd1);

        // R10: idle request high with source loaded
        push_word(16'hA5A5);
        repeat (10) @(negedge clk);
        check("R10 ack idle", 32'(ack_n), 32'd1);
        check("R10 no pop idle", 32'(pops), 32'd0);

        // R2 latency
        rd_req_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 ack high after 3 edges", 32'(ack_n), 32'd1);
        repeat (2) @(negedge clk);
        check("R2 ack low after 5 edges", 32'(ack_n), 32'd0);
        check("R4 word on bus", 32'(bus), 32'hA5A5);
        rd_req_n = 1'b1;
        wait_ack(1'b1, "R6 ack rises");
        repeat (2) @(negedge clk);
        check("R3 single pop", 32'(pops), 32'd1);

        // R9 several words in order
        push_word(16'h0001);
        push_word(16'hFFFF);
        push_word(16'h1234);
        for (int i = 0; i < 3; i++) read_word();
        check("R9 pops per handshake", 32'(pops), 32'd4);

        // R7 empty source
        rd_req_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R7 ack high while empty", 32'(ack_n), 32'd1);
        check("R7 no pop while empty", 32'(pops), 32'd4);
        push_word(16'hBEEF);
        wait_ack(1'b0, "R7 ack after word");
        check("R7 word", 32'(bus), 32'hBEEF);
        rd_req_n = 1'b1;
        wait_ack(1'b1, "R6 ack rises after R7");
        repeat (2) @(negedge clk);

        // R8 request dropped again before ack rises
        push_word(16'h5A5A);
        push_word(16'h7E7E);
        rd_req_n = 1'b0;
        wait_ack(1'b0, "R8 first ack");
        @(negedge clk);
        rd_req_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_req_n = 1'b0;
        p0 = pops;
        repeat (12) @(negedge clk);
        check("R8 ack stays high", 32'(ack_n), 32'd1);
        check("R8 no new pop", 32'(pops), 32'(p0));
        rd_req_n = 1'b1;
        repeat (5) @(negedge clk);
        read_word();
        check("R8 resumes after high", 32'(pops), 32'(p0 + 1));
        check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule